// File: doc/BRIEF.md
# Timer and Counter Pin Allocation Router

This block shares eight flexible I/O lines between six timer functions, two counter functions and ordinary GPIO. Enabled functions are placed onto the lowest lines with no gaps, in a fixed priority order. The timers come first, in ascending index. Counter 0 follows them, and Counter 1 is last. A function's pin therefore depends on which other functions are enabled.

Timers are enabled by count: a count of N enables timers 0 to N-1. Each counter has its own enable bit. The allocation, and the direction each timer asks for, are captured only when the configuration strobe is seen. That strobe also produces a one-cycle re-initialisation pulse for every timer and counter.

Each line carries an owner code. The block drives each allocated line from its function's output and returns each line's input value to the function that owns it. Lines that no function claims follow the GPIO direction and data values.

Top module: `tcpin_router`

## Requirements
- R1: While reset is asserted and after reset until the first strobe, every owner code is 15, `line_dir` equals `gpio_dir`, `line_dout` equals `gpio_dout`, `fn_din` is zero and `cfg_reinit` is low.
- R2: After a strobe, enabled functions occupy lines 0 to K-1 with no gap, ordered as Timer0 to Timer5, then Counter0, then Counter1. The 4-bit owner code of line i sits at `line_owner[4i+3:4i]`. Timers use codes 0 to 5, Counter0 uses 6, Counter1 uses 7 and a free line uses 15.
- R3: A timer count above 6 allocates exactly Timer0 to Timer5.
- R4: While no strobe is seen, changes on `cfg_tmr_cnt`, `cfg_ctr_en` and `cfg_tmr_dir` do not alter `line_owner` or `line_dir`.
- R5: An allocated line drives `fn_out[code]` on `line_dout`. Its `line_dir` is 1 (output) for a timer whose `cfg_tmr_dir` bit was 1 at the strobe, and 0 (input) for any other timer and for both counters.
- R6: `fn_din[f]` equals `line_din` of the line that function f owns, and is 0 when f is not allocated. Bits 0 to 5 of `fn_din` are the timers, bit 6 is Counter0 and bit 7 is Counter1. `cfg_ctr_en` bit 0 enables Counter0 and bit 1 enables Counter1.
- R7: A line never allocated since reset follows `gpio_dir` and `gpio_dout`.
- R8: A line freed by a strobe keeps the direction it had while allocated, until its `gpio_dir` bit changes. From the clock edge that sees the change, the line follows `gpio_dir`. Its data follows `gpio_dout` as soon as it is freed.
- R9: `cfg_reinit` is high for exactly the cycle after each clock edge that samples `cfg_update` high, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_update | input | 1 | Configuration strobe |
| cfg_tmr_cnt | input | 3 | Number of enabled timers (values above 6 are treated as 6) |
| cfg_ctr_en | input | 2 | Counter enables (bit 0 Counter0, bit 1 Counter1) |
| cfg_tmr_dir | input | 6 | Per-timer direction request, 1 = output |
| fn_out | input | 8 | Output value of each function |
| fn_din | output | 8 | Line input value returned to each function |
| gpio_dir | input | 8 | GPIO direction per line, 1 = output |
| gpio_dout | input | 8 | GPIO output data per line |
| line_din | input | 8 | Input value sensed on each line |
| line_dout | output | 8 | Output value driven on each line |
| line_dir | output | 8 | Direction of each line, 1 = output |
| line_owner | output | 32 | Owner code of each line, 4 bits per line |
| cfg_reinit | output | 1 | One-cycle re-initialisation pulse |

## Verification
The assertions check the following on every cycle:
- the no-gap packing and the strictly ascending priority of the owner codes;
- that no function owns more than one line;
- that counter-owned lines are inputs;
- that `fn_din` is silent for disabled functions;
- that owner codes hold between strobes;
- that the re-initialisation pulse is tied exactly to the strobe.

Some behaviours need the bench's scenarios, because they depend on history or on exact expected values:
- the exact line each function lands on for a given configuration, including the clamp of an oversized timer count;
- the data routing in both directions;
- the direction held on a freed line and its release when the GPIO direction changes.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  localparam int  OWN_W_DEF = 4;
  localparam logic DIR_IN   = 1'b0;
  localparam logic DIR_OUT  = 1'b1;
endpackage

// File: rtl/tcr_alloc.sv
module tcr_alloc #(
  parameter int NUM_TMR = 6,
  parameter int NUM_CTR = 2,
  parameter int OWN_W   = tcr_pkg::OWN_W_DEF,
  localparam int NUM_FN = NUM_TMR + NUM_CTR,
  localparam int CNT_W  = $clog2(NUM_TMR + 1),
  localparam int POS_W  = $clog2(NUM_FN)
) (
  input  logic [CNT_W-1:0]        tmr_cnt,
  input  logic [NUM_CTR-1:0]      ctr_en,
  input  logic [NUM_TMR-1:0]      tmr_dir,
  output logic [NUM_FN*OWN_W-1:0] nxt_owner,
  output logic [NUM_FN-1:0]       nxt_fdir,
  output logic [NUM_FN-1:0]       nxt_fen,
  output logic [NUM_FN*POS_W-1:0] nxt_fpos
);
  localparam logic [OWN_W-1:0] FREE = {OWN_W{1'b1}};

  // Limit the requested timer count to the number of timers present.
  function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CNT_W-1:0] c);
    return (int'(c) > NUM_TMR) ? CNT_W'(NUM_TMR) : c;
  endfunction

  // Thermometer mask: timers below the count are enabled.
  function automatic logic [NUM_TMR-1:0] tmr_mask(input logic [CNT_W-1:0] c);
    logic [NUM_TMR-1:0] m;
    for (int t = 0; t < NUM_TMR; t++) m[t] = (t < int'(c));
    return m;
  endfunction

  logic [NUM_FN-1:0] fdir_ext;
  assign fdir_ext = {{NUM_CTR{tcr_pkg::DIR_IN}}, tmr_dir};
  assign nxt_fen  = {ctr_en, tmr_mask(clamp_cnt(tmr_cnt))};

  // Each enabled function takes the next free line in priority order.
  always_comb begin
    int rank;
    rank      = 0;
    nxt_owner = {NUM_FN{FREE}};
    nxt_fdir  = '0;
    nxt_fpos  = '0;
    for (int f = 0; f < NUM_FN; f++) begin
      if (nxt_fen[f]) begin
        nxt_owner[rank*OWN_W +: OWN_W] = OWN_W'(f);
        nxt_fdir[rank]                 = fdir_ext[f];
        nxt_fpos[f*POS_W +: POS_W]     = POS_W'(rank);
        rank++;
      end
    end
  end
endmodule

// File: rtl/tcr_state.sv
module tcr_state #(
  parameter int NUM_FN  = 8,
  parameter int OWN_W   = tcr_pkg::OWN_W_DEF,
  localparam int POS_W  = $clog2(NUM_FN)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_update,
  input  logic [NUM_FN-1:0]       gpio_dir,
  input  logic [NUM_FN*OWN_W-1:0] nxt_owner,
  input  logic [NUM_FN-1:0]       nxt_fdir,
  input  logic [NUM_FN-1:0]       nxt_fen,
  input  logic [NUM_FN*POS_W-1:0] nxt_fpos,
  output logic [NUM_FN*OWN_W-1:0] owner_q,
  output logic [NUM_FN-1:0]       owned_q,
  output logic [NUM_FN-1:0]       fdir_q,
  output logic [NUM_FN-1:0]       fen_q,
  output logic [NUM_FN*POS_W-1:0] fpos_q,
  output logic [NUM_FN-1:0]       held_v,
  output logic [NUM_FN-1:0]       held_d,
  output logic                    reinit_q
);
  localparam logic [OWN_W-1:0] FREE = {OWN_W{1'b1}};

  logic [NUM_FN-1:0] gdir_q;
  logic [NUM_FN-1:0] gdir_chg;
  logic [NUM_FN-1:0] nxt_owned;
  logic [NUM_FN-1:0] hv_n, hd_n;

  assign gdir_chg = gpio_dir ^ gdir_q;

  for (genvar i = 0; i < NUM_FN; i++) begin : g_line
    assign owned_q[i]   = owner_q[i*OWN_W +: OWN_W]   != FREE;
    assign nxt_owned[i] = nxt_owner[i*OWN_W +: OWN_W] != FREE;
  end

  // Direction holding on freed lines: set when a strobe frees an allocated
  // line, dropped on reallocation or on a change of the GPIO direction bit.
  always_comb begin
    for (int i = 0; i < NUM_FN; i++) begin
      hv_n[i] = held_v[i] & ~gdir_chg[i];
      hd_n[i] = held_d[i];
      if (cfg_update) begin
        if (nxt_owned[i]) begin
          hv_n[i] = 1'b0;
        end else if (owned_q[i]) begin
          hv_n[i] = 1'b1;
          hd_n[i] = fdir_q[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q  <= {NUM_FN{FREE}};
      fdir_q   <= '0;
      fen_q    <= '0;
      fpos_q   <= '0;
      held_v   <= '0;
      held_d   <= '0;
      gdir_q   <= '0;
      reinit_q <= 1'b0;
    end else begin
      gdir_q   <= gpio_dir;
      reinit_q <= cfg_update;
      held_v   <= hv_n;
      held_d   <= hd_n;
      if (cfg_update) begin
        owner_q <= nxt_owner;
        fdir_q  <= nxt_fdir;
        fen_q   <= nxt_fen;
        fpos_q  <= nxt_fpos;
      end
    end
  end
endmodule

// File: rtl/tcr_mux.sv
module tcr_mux #(
  parameter int NUM_FN  = 8,
  parameter int OWN_W   = tcr_pkg::OWN_W_DEF,
  localparam int POS_W  = $clog2(NUM_FN)
) (
  input  logic [NUM_FN*OWN_W-1:0] owner_q,
  input  logic [NUM_FN-1:0]       owned_q,
  input  logic [NUM_FN-1:0]       fdir_q,
  input  logic [NUM_FN-1:0]       fen_q,
  input  logic [NUM_FN*POS_W-1:0] fpos_q,
  input  logic [NUM_FN-1:0]       held_v,
  input  logic [NUM_FN-1:0]       held_d,
  input  logic [NUM_FN-1:0]       fn_out,
  input  logic [NUM_FN-1:0]       gpio_dir,
  input  logic [NUM_FN-1:0]       gpio_dout,
  input  logic [NUM_FN-1:0]       line_din,
  output logic [NUM_FN-1:0]       line_dout,
  output logic [NUM_FN-1:0]       line_dir,
  output logic [NUM_FN-1:0]       fn_din
);
  for (genvar i = 0; i < NUM_FN; i++) begin : g_out
    logic [OWN_W-1:0] code;
    assign code = owner_q[i*OWN_W +: OWN_W];
    always_comb begin
      if (owned_q[i]) begin
        line_dout[i] = fn_out[int'(code) % NUM_FN];
        line_dir[i]  = fdir_q[i];
      end else begin
        line_dout[i] = gpio_dout[i];
        line_dir[i]  = held_v[i] ? held_d[i] : gpio_dir[i];
      end
    end
  end

  for (genvar f = 0; f < NUM_FN; f++) begin : g_in
    logic [POS_W-1:0] pos;
    assign pos       = fpos_q[f*POS_W +: POS_W];
    assign fn_din[f] = fen_q[f] & line_din[pos];
  end
endmodule

// File: rtl/tcpin_router.sv
module tcpin_router #(
  parameter int NUM_TMR = 6,
  parameter int NUM_CTR = 2,
  parameter int OWN_W   = tcr_pkg::OWN_W_DEF
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    cfg_update,
  input  logic [$clog2(NUM_TMR+1)-1:0]            cfg_tmr_cnt,
  input  logic [NUM_CTR-1:0]                      cfg_ctr_en,
  input  logic [NUM_TMR-1:0]                      cfg_tmr_dir,
  input  logic [NUM_TMR+NUM_CTR-1:0]              fn_out,
  output logic [NUM_TMR+NUM_CTR-1:0]              fn_din,
  input  logic [NUM_TMR+NUM_CTR-1:0]              gpio_dir,
  input  logic [NUM_TMR+NUM_CTR-1:0]              gpio_dout,
  input  logic [NUM_TMR+NUM_CTR-1:0]              line_din,
  output logic [NUM_TMR+NUM_CTR-1:0]              line_dout,
  output logic [NUM_TMR+NUM_CTR-1:0]              line_dir,
  output logic [(NUM_TMR+NUM_CTR)*OWN_W-1:0]      line_owner,
  output logic                                    cfg_reinit
);
  localparam int NUM_FN = NUM_TMR + NUM_CTR;
  localparam int POS_W  = $clog2(NUM_FN);

  logic [NUM_FN*OWN_W-1:0] nxt_owner;
  logic [NUM_FN-1:0]       nxt_fdir, nxt_fen;
  logic [NUM_FN*POS_W-1:0] nxt_fpos;
  logic [NUM_FN-1:0]       owned_w, fdir_w, fn_en_w, held_v_w, held_d_w;
  logic [NUM_FN*POS_W-1:0] fpos_w;

  tcr_alloc #(.NUM_TMR(NUM_TMR), .NUM_CTR(NUM_CTR), .OWN_W(OWN_W)) u_alloc (
    .tmr_cnt(cfg_tmr_cnt), .ctr_en(cfg_ctr_en), .tmr_dir(cfg_tmr_dir),
    .nxt_owner(nxt_owner), .nxt_fdir(nxt_fdir), .nxt_fen(nxt_fen),
    .nxt_fpos(nxt_fpos)
  );

  tcr_state #(.NUM_FN(NUM_FN), .OWN_W(OWN_W)) u_state (
    .clk(clk), .rst_n(rst_n), .cfg_update(cfg_update), .gpio_dir(gpio_dir),
    .nxt_owner(nxt_owner), .nxt_fdir(nxt_fdir), .nxt_fen(nxt_fen),
    .nxt_fpos(nxt_fpos), .owner_q(line_owner), .owned_q(owned_w),
    .fdir_q(fdir_w), .fen_q(fn_en_w), .fpos_q(fpos_w), .held_v(held_v_w),
    .held_d(held_d_w), .reinit_q(cfg_reinit)
  );

  tcr_mux #(.NUM_FN(NUM_FN), .OWN_W(OWN_W)) u_mux (
    .owner_q(line_owner), .owned_q(owned_w), .fdir_q(fdir_w),
    .fen_q(fn_en_w), .fpos_q(fpos_w), .held_v(held_v_w), .held_d(held_d_w),
    .fn_out(fn_out), .gpio_dir(gpio_dir), .gpio_dout(gpio_dout),
    .line_din(line_din), .line_dout(line_dout), .line_dir(line_dir),
    .fn_din(fn_din)
  );
endmodule

// File: rtl/tcr_checker.sv
module tcr_checker #(
  parameter int NUM_TMR = 6,
  parameter int NUM_CTR = 2,
  parameter int OWN_W   = 4,
  localparam int NUM_FN = NUM_TMR + NUM_CTR
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_update,
  input logic                    cfg_reinit,
  input logic [NUM_FN*OWN_W-1:0] line_owner,
  input logic [NUM_FN-1:0]       line_dir,
  input logic [NUM_FN-1:0]       fn_en,
  input logic [NUM_FN-1:0]       fn_din
);
  localparam logic [OWN_W-1:0] FREE = {OWN_W{1'b1}};

  logic [NUM_FN-1:0] owned, owned_inc;
  logic [NUM_FN-1:0] match [NUM_FN];

  always_comb begin
    for (int i = 0; i < NUM_FN; i++) begin
      owned[i] = line_owner[i*OWN_W +: OWN_W] != FREE;
      for (int f = 0; f < NUM_FN; f++)
        match[f][i] = line_owner[i*OWN_W +: OWN_W] == OWN_W'(f);
    end
  end
  assign owned_inc = owned + {{(NUM_FN-1){1'b0}}, 1'b1};

  a_r2_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (owned & owned_inc) == '0);

  for (genvar f = 0; f < NUM_FN; f++) begin : g_fn
    a_r2_unique: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match[f]));
  end

  for (genvar i = 0; i + 1 < NUM_FN; i++) begin : g_ord
    a_r2_order: assert property (@(posedge clk) disable iff (!rst_n)
      owned[i+1] |-> (line_owner[i*OWN_W +: OWN_W] < line_owner[(i+1)*OWN_W +: OWN_W]));
  end

  for (genvar i = 0; i < NUM_FN; i++) begin : g_dir
    a_r5_ctr_input: assert property (@(posedge clk) disable iff (!rst_n)
      (owned[i] && (int'(line_owner[i*OWN_W +: OWN_W]) >= NUM_TMR)) |-> !line_dir[i]);
  end

  a_r6_idle_din: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_din & ~fn_en) == '0);

  a_r4_owner_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_update) |-> $stable(line_owner));

  a_r9_reinit_set: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_update |=> cfg_reinit);

  a_r9_reinit_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_update) |-> !cfg_reinit);
endmodule

bind tcpin_router tcr_checker #(.NUM_TMR(NUM_TMR), .NUM_CTR(NUM_CTR), .OWN_W(OWN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_update(cfg_update), .cfg_reinit(cfg_reinit),
  .line_owner(line_owner), .line_dir(line_dir), .fn_en(fn_en_w), .fn_din(fn_din)
);

// File: tb/tcpin_router_tb.sv
module tcpin_router_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_update = 1'b0;
  logic [2:0] cfg_tmr_cnt = '0;
  logic [1:0] cfg_ctr_en = '0;
  logic [5:0] cfg_tmr_dir = '0;
  logic [7:0] fn_out = '0, gpio_dir = 8'hC3, gpio_dout = 8'hA5, line_din = '0;
  logic [7:0] fn_din, line_dout, line_dir;
  logic [31:0] line_owner;
  logic       cfg_reinit;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  // Expected-state model: owner word, captured timer dirs, held directions.
  logic [31:0] m_owner = 32'hFFFF_FFFF;
  logic [5:0]  m_tdir = '0;
  logic [7:0]  m_hv = '0, m_hd = '0;

  // {tcnt[2:0], ctr_en[1:0], tmr_dir[5:0], expected owner word[31:0]}
  localparam logic [42:0] VEC [8] = '{
    {3'd1, 2'b00, 6'b000001, 32'hFFFF_FFF0},
    {3'd1, 2'b10, 6'b000000, 32'hFFFF_FF70},
    {3'd6, 2'b11, 6'b101010, 32'h7654_3210},
    {3'd0, 2'b01, 6'b111111, 32'hFFFF_FFF6},
    {3'd0, 2'b00, 6'b000000, 32'hFFFF_FFFF},
    {3'd7, 2'b00, 6'b010101, 32'hFF54_3210},
    {3'd3, 2'b11, 6'b000110, 32'hFFF7_6210},
    {3'd0, 2'b10, 6'b111111, 32'hFFFF_FFF7}
  };

  tcpin_router u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_update(cfg_update), .cfg_tmr_cnt(cfg_tmr_cnt),
    .cfg_ctr_en(cfg_ctr_en), .cfg_tmr_dir(cfg_tmr_dir), .fn_out(fn_out),
    .fn_din(fn_din), .gpio_dir(gpio_dir), .gpio_dout(gpio_dout),
    .line_din(line_din), .line_dout(line_dout), .line_dir(line_dir),
    .line_owner(line_owner), .cfg_reinit(cfg_reinit)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [3:0] code_of(input logic [31:0] w, input int i);
    return w[i*4 +: 4];
  endfunction

  function automatic logic [7:0] exp_dir();
    logic [7:0] d;
    for (int i = 0; i < 8; i++) begin
      logic [3:0] c = code_of(m_owner, i);
      if (c != 4'hF)  d[i] = (c < 4'd6) ? m_tdir[c[2:0]] : 1'b0;
      else if (m_hv[i]) d[i] = m_hd[i];
      else            d[i] = gpio_dir[i];
    end
    return d;
  endfunction

  function automatic logic [7:0] exp_dout();
    logic [7:0] d;
    for (int i = 0; i < 8; i++) begin
      logic [3:0] c = code_of(m_owner, i);
      d[i] = (c != 4'hF) ? fn_out[c[2:0]] : gpio_dout[i];
    end
    return d;
  endfunction

  function automatic logic [7:0] exp_fdin();
    logic [7:0] d = '0;
    for (int i = 0; i < 8; i++) begin
      logic [3:0] c = code_of(m_owner, i);
      if (c != 4'hF) d[c[2:0]] = line_din[i];
    end
    return d;
  endfunction

  // Apply a configuration with a one-cycle strobe and update the model (R8 rule).
  task automatic apply_cfg(input logic [2:0] tc, input logic [1:0] ce,
                           input logic [5:0] td, input logic [31:0] new_owner);
    logic [7:0] old_dir = exp_dir();
    @(negedge clk);
    cfg_tmr_cnt = tc; cfg_ctr_en = ce; cfg_tmr_dir = td; cfg_update = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (code_of(new_owner, i) != 4'hF) m_hv[i] = 1'b0;
      else if (code_of(m_owner, i) != 4'hF) begin m_hv[i] = 1'b1; m_hd[i] = old_dir[i]; end
    end
    m_owner = new_owner;
    m_tdir  = td;
    @(negedge clk);
    cfg_update = 1'b0;
  endtask

  task automatic check_routes(input string tag);
    #1;
    chk({24'd0, line_dout}, {24'd0, exp_dout()}, {tag, " R5/R7 line_dout"});
    chk({24'd0, line_dir},  {24'd0, exp_dir()},  {tag, " R5/R8 line_dir"});
    chk({24'd0, fn_din},    {24'd0, exp_fdin()}, {tag, " R6 fn_din"});
  endtask

  initial begin
    // R1: reset state
    fn_out = 8'hB2; line_din = 8'h5A;
    repeat (3) @(negedge clk);
    chk(line_owner, 32'hFFFF_FFFF, "R1 owners in reset");
    chk({31'd0, cfg_reinit}, 32'd0, "R1 reinit in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(line_owner, 32'hFFFF_FFFF, "R1 owners after reset");
    chk({24'd0, line_dir}, {24'd0, gpio_dir}, "R1/R7 dir follows gpio");
    chk({24'd0, line_dout}, {24'd0, gpio_dout}, "R1/R7 dout follows gpio");
    chk({24'd0, fn_din}, 32'd0, "R1 fn_din zero");

    // Table walk: R2, R3, R5, R6, R7, R8, R9
    for (int v = 0; v < 8; v++) begin
      apply_cfg(VEC[v][42:40], VEC[v][39:38], VEC[v][37:32], VEC[v][31:0]);
      chk(line_owner, VEC[v][31:0], (v == 5) ? "R3 clamped owners" : "R2 owner packing");
      chk({31'd0, cfg_reinit}, 32'd1, "R9 reinit after strobe");
      fn_out = 8'hB2; line_din = 8'h5A;
      check_routes("pattern A");
      @(negedge clk);
      chk({31'd0, cfg_reinit}, 32'd0, "R9 reinit single cycle");
      fn_out = 8'h4D; line_din = 8'hA5;
      check_routes("pattern B");
    end

    // R4: inputs change without strobe
    apply_cfg(3'd2, 2'b01, 6'b000011, 32'hFFFF_F610);
    @(negedge clk);
    cfg_tmr_cnt = 3'd6; cfg_ctr_en = 2'b11; cfg_tmr_dir = 6'b000000;
    repeat (3) @(negedge clk);
    chk(line_owner, 32'hFFFF_F610, "R4 owners held without strobe");
    chk({24'd0, line_dir}, {24'd0, exp_dir()}, "R4 dir held without strobe");
    chk({31'd0, cfg_reinit}, 32'd0, "R9 no reinit without strobe");

    // R8: freed-line direction hold and release
    apply_cfg(3'd6, 2'b11, 6'b101010, 32'h7654_3210);
    apply_cfg(3'd0, 2'b00, 6'b000000, 32'hFFFF_FFFF);
    #1;
    chk({24'd0, line_dir}, 32'h0000_002A, "R8 freed lines keep dir");
    chk({24'd0, line_dout}, {24'd0, gpio_dout}, "R8 freed data follows gpio");
    @(negedge clk);
    gpio_dir[1] = 1'b0;
    #1;
    chk({31'd0, line_dir[1]}, 32'd1, "R8 held before edge");
    @(negedge clk);
    m_hv[1] = 1'b0;
    chk({31'd0, line_dir[1]}, 32'd0, "R8 released after change");
    chk({31'd0, line_dir[0]}, 32'd0, "R8 other line still held");
    gpio_dir[1] = 1'b1;
    @(negedge clk);
    chk({31'd0, line_dir[1]}, 32'd1, "R8 follows gpio after release");

    // R7: changing gpio on free line
    gpio_dout = 8'h3C;
    #1;
    chk({24'd0, line_dout}, 32'h0000_003C, "R7 free data passthrough");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule